// File: doc/BRIEF.md
# Frame-Processor Microcode Sequencer

This block is the instruction-pointer and execution-control stage of a small microcoded engine that works through Ethernet frame data one item at a time. It keeps an 8-bit instruction pointer into a 48-bit-wide instruction store, decodes the 4-bit opcode, and chooses the next address. The choices are: step forward, jump, call a subroutine with a single-entry return register, return, or branch on a static strap input. The strap is tied high on one instance and low on another, so a single program image can drive both the receive and the transmit engines.

Each instruction either runs on every clock or waits until the frame-data source asserts `data_valid_i`. While an instruction waits, the pointer, the return register and every load strobe hold still. A per-instruction ready bit is passed to the data source to pace the incoming stream. The store sits outside the block and is a synchronous ROM. The block presents the next address on `fetch_addr_o`, and the ROM returns the instruction for `ip_o` on `instr_i` one clock later. The ALU, its operand multiplexer and the working registers are outside this block. The block only passes on their decoded strobes and the 16-bit immediate.

Top module: `fp_useq`

## Requirements
- R1: Asynchronous reset (rst_ni low) sets the instruction pointer to 0 and the return register to 0.
- R2: Opcodes 0x0 to 0xB in instr bits 3:0 are sequential: an executed one advances the pointer by one, and 255 wraps to 0.
- R3: An executed opcode 0xC loads the pointer from the target field, instr bits 31:24.
- R4: An executed opcode 0xD loads the pointer from the target field and stores the pointer plus one in the single return register, replacing any earlier value.
- R5: An executed opcode 0xE loads the pointer from the return register, which gives 0 if no call has run since reset.
- R6: An executed opcode 0xF loads the pointer from the target field when branch_sel_i is high, and from instr bits 39:32 (the low byte of the immediate) when it is low.
- R7: An instruction with bit 4 set executes in every cycle. With bit 4 clear, it executes only in a cycle with data_valid_i high. exec_o reports this, and in a non-executing cycle the pointer and the return register hold.
- R8: req_data_o equals instr bit 5 of the current instruction, whether or not the instruction executes in that cycle.
- R9: The strobes are load_wr_o[3:0] = bits 9:6, load_lc_o = bit 10, shift_en_o = bit 11, mask_en_o = bit 12, mask_sel_o = bit 13 and src_sel_o = bits 16:14. Each strobe is forced to 0 when exec_o is low. data_o equals bits 47:32 at all times.
- R10: fetch_addr_o shows the pointer value for the next cycle, so a store registered on that address delivers the instruction for ip_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 48 | Instruction at ip_o, from the synchronous store |
| data_valid_i | input | 1 | Frame data item present |
| branch_sel_i | input | 1 | Static direction strap for opcode 0xF |
| fetch_addr_o | output | 8 | Address to the store for the next cycle |
| ip_o | output | 8 | Current instruction pointer |
| exec_o | output | 1 | Current instruction executes this cycle |
| req_data_o | output | 1 | Ready for the next frame data item |
| load_wr_o | output | 4 | Working-register load strobes |
| load_lc_o | output | 1 | Loop-counter load strobe |
| shift_en_o | output | 1 | Barrel shifter enable |
| mask_en_o | output | 1 | AND-mask enable |
| mask_sel_o | output | 1 | Mask field layout select |
| src_sel_o | output | 3 | ALU second operand select |
| data_o | output | 16 | Immediate field |

## Verification
The hardest case to reach from the ports is a call or branch that is gated on data_valid_i and stalls for several cycles. During the stall the return register must not move, and that can only be seen later through the address a return jumps to. The program places a gated call directly before its subroutine's return and drives data_valid_i at random, so stalls of varied length fall on the call, on the strap branch and on the return. The same program is run once with the strap high and once with it low. A final run puts a return at address 0 straight after reset, to show the empty return register.

// File: rtl/fp_useq_pkg.sv
package fp_useq_pkg;
  localparam int OPC_W     = 4;
  localparam int BIT_ONCLK = 4;
  localparam int BIT_REQ   = 5;
  localparam int BIT_WR0   = 6;
  localparam int NUM_WR    = 4;
  localparam int BIT_LC    = 10;
  localparam int BIT_SHIFT = 11;
  localparam int BIT_MASK  = 12;
  localparam int BIT_MSEL  = 13;
  localparam int SRC_LSB   = 14;
  localparam int SRC_W     = 3;
  localparam int TGT_LSB   = 24;
  localparam int IMM_LSB   = 32;

  localparam logic [OPC_W-1:0] OP_JUMP  = 4'hC;
  localparam logic [OPC_W-1:0] OP_CALL  = 4'hD;
  localparam logic [OPC_W-1:0] OP_RET   = 4'hE;
  localparam logic [OPC_W-1:0] OP_STRAP = 4'hF;

  typedef struct packed {
    logic [NUM_WR-1:0] load_wr;
    logic              load_lc;
    logic              shift_en;
    logic              mask_en;
    logic              mask_sel;
    logic [SRC_W-1:0]  src_sel;
  } ctrl_t;
endpackage

// File: rtl/fp_useq_decode.sv
module fp_useq_decode
  import fp_useq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  localparam int INSTR_W = IMM_LSB + DATA_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               data_valid_i,
  output logic [OPC_W-1:0]   opcode_o,
  output logic               exec_o,
  output logic               req_o,
  output ctrl_t              ctrl_o,
  output logic [ADDR_W-1:0]  target_o,
  output logic [DATA_W-1:0]  imm_o
);
  logic unused_bits;
  assign unused_bits = ^instr_i[TGT_LSB-1:SRC_LSB+SRC_W];

  assign opcode_o = instr_i[OPC_W-1:0];
  assign exec_o   = instr_i[BIT_ONCLK] | data_valid_i;
  assign req_o    = instr_i[BIT_REQ];
  assign target_o = instr_i[TGT_LSB +: ADDR_W];
  assign imm_o    = instr_i[IMM_LSB +: DATA_W];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_wr
    assign ctrl_o.load_wr[g] = exec_o & instr_i[BIT_WR0+g];
  end

  assign ctrl_o.load_lc  = exec_o & instr_i[BIT_LC];
  assign ctrl_o.shift_en = exec_o & instr_i[BIT_SHIFT];
  assign ctrl_o.mask_en  = exec_o & instr_i[BIT_MASK];
  assign ctrl_o.mask_sel = exec_o & instr_i[BIT_MSEL];
  assign ctrl_o.src_sel  = exec_o ? instr_i[SRC_LSB +: SRC_W] : '0;
endmodule

// File: rtl/fp_useq_next.sv
module fp_useq_next
  import fp_useq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              exec_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ADDR_W-1:0] ret_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] imm_lo_i,
  input  logic              strap_i,
  output logic [ADDR_W-1:0] next_o,
  output logic [ADDR_W-1:0] link_o,
  output logic              save_o
);
  assign link_o = ip_i + ADDR_W'(1);
  assign save_o = exec_i && (opcode_i == OP_CALL);

  always_comb begin
    next_o = ip_i;
    if (exec_i) begin
      unique case (opcode_i)
        OP_JUMP, OP_CALL: next_o = target_i;
        OP_RET:           next_o = ret_i;
        OP_STRAP:         next_o = strap_i ? target_i : imm_lo_i;
        default:          next_o = link_o;
      endcase
    end
  end
endmodule

// File: rtl/fp_useq_link.sv
module fp_useq_link #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic [ADDR_W-1:0] link_i,
  output logic [ADDR_W-1:0] ret_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ret_o <= '0;
    else if (save_i) ret_o <= link_i;
  end
endmodule

// File: rtl/fp_useq.sv
module fp_useq
  import fp_useq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int INSTR_W = IMM_LSB + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               data_valid_i,
  input  logic               branch_sel_i,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic [ADDR_W-1:0]  ip_o,
  output logic               exec_o,
  output logic               req_data_o,
  output logic [NUM_WR-1:0]  load_wr_o,
  output logic               load_lc_o,
  output logic               shift_en_o,
  output logic               mask_en_o,
  output logic               mask_sel_o,
  output logic [SRC_W-1:0]   src_sel_o,
  output logic [DATA_W-1:0]  data_o
);
  logic [ADDR_W-1:0] ip_q, ip_d, ret_q, target, link;
  logic [OPC_W-1:0]  opcode;
  logic              exec, save;
  ctrl_t             ctrl;

  fp_useq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .instr_i      (instr_i),
    .data_valid_i (data_valid_i),
    .opcode_o     (opcode),
    .exec_o       (exec),
    .req_o        (req_data_o),
    .ctrl_o       (ctrl),
    .target_o     (target),
    .imm_o        (data_o)
  );

  fp_useq_next #(.ADDR_W(ADDR_W)) u_next (
    .exec_i   (exec),
    .opcode_i (opcode),
    .ip_i     (ip_q),
    .ret_i    (ret_q),
    .target_i (target),
    .imm_lo_i (data_o[ADDR_W-1:0]),
    .strap_i  (branch_sel_i),
    .next_o   (ip_d),
    .link_o   (link),
    .save_o   (save)
  );

  fp_useq_link #(.ADDR_W(ADDR_W)) u_link (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .save_i (save),
    .link_i (link),
    .ret_o  (ret_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ip_q <= '0;
    else         ip_q <= ip_d;
  end

  assign fetch_addr_o = ip_d;
  assign ip_o         = ip_q;
  assign exec_o       = exec;
  assign load_wr_o    = ctrl.load_wr;
  assign load_lc_o    = ctrl.load_lc;
  assign shift_en_o   = ctrl.shift_en;
  assign mask_en_o    = ctrl.mask_en;
  assign mask_sel_o   = ctrl.mask_sel;
  assign src_sel_o    = ctrl.src_sel;

  assert_fetch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ip_q == $past(fetch_addr_o));
  assert_stall_ip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> ip_q == $past(ip_q));
  assert_stall_ret_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> ret_q == $past(ret_q));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode < OP_JUMP) |=> ip_q == ADDR_W'($past(ip_q) + ADDR_W'(1)));
  assert_jump_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode == OP_JUMP) |=> ip_q == $past(instr_i[TGT_LSB +: ADDR_W]));
  assert_call_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode == OP_CALL) |=> ret_q == ADDR_W'($past(ip_q) + ADDR_W'(1)));
  assert_ret_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode == OP_RET) |=> ip_q == $past(ret_q));
  assert_strap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && opcode == OP_STRAP) |=> ip_q == ($past(branch_sel_i)
      ? $past(instr_i[TGT_LSB +: ADDR_W]) : $past(instr_i[IMM_LSB +: ADDR_W])));
  assert_idle_ctrl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |-> (load_wr_o == '0 && !load_lc_o && !shift_en_o && !mask_en_o
                 && !mask_sel_o && src_sel_o == '0));
endmodule

// File: tb/fp_useq_tb_top.sv
module fp_useq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] rom [256];
  logic [47:0] rom_q;
  logic        dv = 1'b0;
  logic        strap = 1'b1;
  logic [7:0]  fetch, ip;
  logic        ex, req, lc, sh, mk, ms;
  logic [3:0]  wr;
  logic [2:0]  src;
  logic [15:0] dat;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  int m_ip = 0, m_ret = 0;

  always #2 clk = ~clk;

  fp_useq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(rom_q), .data_valid_i(dv),
    .branch_sel_i(strap), .fetch_addr_o(fetch), .ip_o(ip), .exec_o(ex),
    .req_data_o(req), .load_wr_o(wr), .load_lc_o(lc), .shift_en_o(sh),
    .mask_en_o(mk), .mask_sel_o(ms), .src_sel_o(src), .data_o(dat));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) rom_q <= rom[0];
    else        rom_q <= rom[fetch];

  function automatic logic [47:0] mk_ins(int op, bit onclk, bit rq, int tgt, int imm, int ctl);
    logic [47:0] w = '0;
    w[3:0] = 4'(op); w[4] = onclk; w[5] = rq;
    w[16:6] = 11'(ctl); w[31:24] = 8'(tgt); w[47:32] = 16'(imm);
    return w;
  endfunction

  function automatic int ref_next(int p, int r, bit d, bit s);
    logic [47:0] w = rom[p];
    if (!(w[4] || d)) return p;
    case (w[3:0])
      4'hC, 4'hD: return int'(w[31:24]);
      4'hE:       return r;
      4'hF:       return s ? int'(w[31:24]) : int'(w[39:32]);
      default:    return (p + 1) % 256;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_ip = 0; m_ret = 0; end
    else begin
      int nx;
      nx = ref_next(m_ip, m_ret, dv, strap);
      if ((rom[m_ip][4] || dv) && rom[m_ip][3:0] == 4'hD) m_ret = (m_ip + 1) % 256;
      m_ip = nx;
    end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (ip model %0h)", tag, act, exp, m_ip);
    end
  endtask

  task automatic compare();
    logic [47:0] w = rom[m_ip];
    bit e = w[4] || dv;
    chk("R1/R2/R3/R4/R5/R6 ip", ip, m_ip);
    chk("R7 exec", ex, e);
    chk("R8 req", req, w[5]);
    chk("R9 load_wr", wr, e ? w[9:6] : 4'h0);
    chk("R9 lc/shift/mask", {lc, sh, mk, ms}, e ? {w[10], w[11], w[12], w[13]} : 4'h0);
    chk("R9 src_sel", src, e ? w[16:14] : 3'h0);
    chk("R9 data", dat, w[47:32]);
    chk("R10 fetch", fetch, ref_next(m_ip, m_ret, dv, strap));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      dv = ($urandom_range(0, 2) != 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ip reset", ip, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) rom[a] = mk_ins(a % 12, 1, a[0], 0, a * 7, a * 37);
    rom[8'h00] = mk_ins(4'h0, 1, 1, 0, 16'h1234, 11'h00F);
    rom[8'h01] = mk_ins(4'h3, 0, 1, 0, 16'hBEEF, 11'h7F0);
    rom[8'h02] = mk_ins(4'hD, 0, 0, 8'h40, 0, 11'h010);   // gated call
    rom[8'h03] = mk_ins(4'hF, 0, 1, 8'h10, 16'h0020, 11'h155);
    rom[8'h10] = mk_ins(4'hD, 1, 0, 8'h50, 0, 11'h0AA);   // call overwrites
    rom[8'h11] = mk_ins(4'hC, 0, 1, 8'hFE, 0, 11'h2A5);
    rom[8'h20] = mk_ins(4'h7, 0, 1, 0, 16'h5A5A, 11'h3C3);
    rom[8'h21] = mk_ins(4'hC, 1, 0, 8'hFE, 0, 0);
    rom[8'h40] = mk_ins(4'h2, 1, 1, 0, 16'hCAFE, 11'h041);
    rom[8'h41] = mk_ins(4'hE, 0, 0, 0, 0, 11'h7FF);
    rom[8'h50] = mk_ins(4'hE, 1, 1, 0, 0, 0);
    rom[8'hFE] = mk_ins(4'h1, 1, 0, 0, 0, 0);
    rom[8'hFF] = mk_ins(4'hB, 0, 1, 0, 0, 11'h100);       // wraps to 0
    strap = 1'b1;
    do_reset();
    run(600);                                             // R6 strap high path
    strap = 1'b0;
    do_reset();
    run(600);                                             // R6 strap low path
    rom[8'h00] = mk_ins(4'hE, 1, 0, 8'h33, 0, 0);         // R5 return without call
    do_reset();
    run(20);
    chk("R5 empty return ip", ip, 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected done", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule